// File: doc/BRIEF.md
# Byte-Wide Memory Chip-Enable Decoder

This block turns one memory cycle (a 16-bit logical address, a flag for program fetch or data access, and a write flag) into the select lines of a byte-wide static RAM bus. Program space and data space are each 64K. Together they form a 128K physical space, with the data space in the upper half. That space is served either by four 32K RAMs, each with its own active-low chip enable, or by a single 128K RAM. In the single-RAM setting, two of the chip-enable pins carry the two upper physical address bits. A peripheral-select input diverts data cycles onto four 16K peripheral enables. Program fetches are never diverted.

A partition limit input marks the program region: the logical addresses below the limit. A program fetch at or above the limit is not served by the byte-wide bus, so it is left to the multiplexed expansion bus and raises no enable. A data access below the limit falls in program-marked memory. It can be read, but its write strobe is held off. All outputs are registered, with one clock of latency, and a synchronous reset parks every pin high.

Top module: `bwce_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are all ones: `ce_n`, `pe_n` and `wr_n`.
- R2: With `mem_big`=0, an SRAM cycle drives low exactly one chip enable, `ce_n[k]`, where k = {data, addr[15]} and data is 1 for a data cycle and 0 for a program fetch. The other bits stay high.
- R3: With `mem_big`=1, an SRAM cycle drives `ce_n[0]` low, `ce_n[1]` to the data-space bit (address bit 16) and `ce_n[2]` to addr[15]. `ce_n[3]` stays high in every cycle of this mode.
- R4: A data cycle with `periph_sel`=1 drives `pe_n[addr[15:14]]` low and keeps all `ce_n` high. The windows are 0000h-3FFFh for pe 0, 4000h-7FFFh for pe 1, 8000h-BFFFh for pe 2 and C000h-FFFFh for pe 3.
- R5: `periph_sel` has no effect on program fetches.
- R6: A program fetch with address >= `part_lim` raises no enable and keeps `wr_n` high.
- R7: `wr_n` goes low only for a data write. For an SRAM data write, the address must also be >= `part_lim`; peripheral writes are always allowed. A data write below the limit still asserts its chip enable, with `wr_n` high.
- R8: When `cyc_act` is 0, all outputs go high.
- R9: At most one enable is low in any cycle. In the 128K setting, `ce_n[1]` and `ce_n[2]` are address bits and are not counted.
- R10: Each output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_act | input | 1 | A memory cycle is presented this clock |
| cyc_prog | input | 1 | 1 = program fetch, 0 = data access |
| cyc_wr | input | 1 | 1 = write cycle |
| periph_sel | input | 1 | Route data cycles to the peripheral windows |
| mem_big | input | 1 | 1 = one 128K RAM, 0 = four 32K RAMs |
| part_lim | input | 17 | Partition limit; addresses below it are program-marked |
| log_addr | input | 16 | Logical address |
| ce_n | output | 4 | Chip enables, active low (two become address bits in the 128K setting) |
| pe_n | output | 4 | Peripheral enables, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
A corrupted routing decision shows up at the pins on the clock after the cycle is presented. It takes one of three forms: a second enable low alongside the first, a wrong chip or window index, or a write strobe on program-marked memory. Because there is no state beyond the output register, an error cannot stay hidden and surface later. It can only appear as a wrong value for the exact cycle that caused it. The sweep therefore covers every window edge and both sides of the partition limit in each mode, and checks each registered result against a model that is independent of the RTL.

// File: rtl/bwce_pkg.sv
package bwce_pkg;
    localparam int ADDR_W  = 16;
    localparam int N_CHIP  = 4;
    localparam int N_PERI  = 4;
    localparam int PHYS_W  = ADDR_W + 1;
    localparam int CHIP_W  = $clog2(N_CHIP);
    localparam int PERI_W  = $clog2(N_PERI);
    // pins that carry upper physical address bits in the single-RAM setting
    localparam int PIN_HI  = 1;
    localparam int PIN_MID = 2;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_SRAM = 2'd1,
        TGT_PERI = 2'd2
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [PHYS_W-1:0] phys;
        logic              wr_ok;
    } route_t;

    typedef struct packed {
        logic [N_CHIP-1:0] ce_n;
        logic [N_PERI-1:0] pe_n;
        logic              wr_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{ce_n: '1, pe_n: '1, wr_n: 1'b1};

    function automatic logic below_lim(input logic [ADDR_W-1:0] a,
                                       input logic [PHYS_W-1:0] lim);
        return ({1'b0, a} < lim);
    endfunction
endpackage

// File: rtl/bwce_route.sv
module bwce_route
    import bwce_pkg::*;
(
    input  logic              act,
    input  logic              is_prog,
    input  logic              is_wr,
    input  logic              psel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PHYS_W-1:0] lim,
    output route_t            rt
);
    logic in_prog_zone;

    always_comb begin
        in_prog_zone = below_lim(addr, lim);
        rt.tgt   = TGT_NONE;
        rt.wr_ok = 1'b0;
        rt.phys  = {~is_prog, addr};
        if (act) begin
            if (is_prog) begin
                if (in_prog_zone) rt.tgt = TGT_SRAM;
            end else if (psel) begin
                rt.tgt   = TGT_PERI;
                rt.wr_ok = is_wr;
            end else begin
                rt.tgt   = TGT_SRAM;
                rt.wr_ok = is_wr && !in_prog_zone;
            end
        end
    end
endmodule

// File: rtl/bwce_chip_pins.sv
module bwce_chip_pins
    import bwce_pkg::*;
(
    input  route_t            rt,
    input  logic              big,
    output logic [N_CHIP-1:0] ce_n
);
    logic                  hit;
    logic [CHIP_W-1:0]     blk;

    assign hit = (rt.tgt == TGT_SRAM);
    assign blk = rt.phys[PHYS_W-1 -: CHIP_W];

    for (genvar k = 0; k < N_CHIP; k++) begin : g_chip
        logic small_n;
        logic big_n;
        assign small_n = !(hit && (blk == CHIP_W'(k)));
        if (k == 0) begin : g_sel
            assign big_n = !hit;
        end else if (k == PIN_HI) begin : g_a16
            assign big_n = hit ? rt.phys[PHYS_W-1] : 1'b1;
        end else if (k == PIN_MID) begin : g_a15
            assign big_n = hit ? rt.phys[PHYS_W-2] : 1'b1;
        end else begin : g_unused
            assign big_n = 1'b1;
        end
        assign ce_n[k] = big ? big_n : small_n;
    end
endmodule

// File: rtl/bwce_peri_pins.sv
module bwce_peri_pins
    import bwce_pkg::*;
(
    input  route_t            rt,
    output logic [N_PERI-1:0] pe_n
);
    logic [PERI_W-1:0] win;

    assign win = rt.phys[ADDR_W-1 -: PERI_W];

    for (genvar j = 0; j < N_PERI; j++) begin : g_win
        assign pe_n[j] = !((rt.tgt == TGT_PERI) && (win == PERI_W'(j)));
    end
endmodule

// File: rtl/bwce_decoder.sv
module bwce_decoder
    import bwce_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_act,
    input  logic              cyc_prog,
    input  logic              cyc_wr,
    input  logic              periph_sel,
    input  logic              mem_big,
    input  logic [PHYS_W-1:0] part_lim,
    input  logic [ADDR_W-1:0] log_addr,
    output logic [N_CHIP-1:0] ce_n,
    output logic [N_PERI-1:0] pe_n,
    output logic              wr_n
);
    route_t            rt;
    logic [N_CHIP-1:0] ce_c;
    logic [N_PERI-1:0] pe_c;
    pins_t             nxt;
    pins_t             cur;

    bwce_route u_route (
        .act     (cyc_act),
        .is_prog (cyc_prog),
        .is_wr   (cyc_wr),
        .psel    (periph_sel),
        .addr    (log_addr),
        .lim     (part_lim),
        .rt      (rt)
    );

    bwce_chip_pins u_chip (
        .rt   (rt),
        .big  (mem_big),
        .ce_n (ce_c)
    );

    bwce_peri_pins u_peri (
        .rt   (rt),
        .pe_n (pe_c)
    );

    always_comb begin
        nxt.ce_n = ce_c;
        nxt.pe_n = pe_c;
        nxt.wr_n = !rt.wr_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= PINS_IDLE;
        else     cur <= nxt;
    end

    assign ce_n = cur.ce_n;
    assign pe_n = cur.pe_n;
    assign wr_n = cur.wr_n;
endmodule

// File: rtl/bwce_chk.sv
module bwce_chk
    import bwce_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cyc_act,
    input logic              cyc_prog,
    input logic              cyc_wr,
    input logic              periph_sel,
    input logic              mem_big,
    input logic [PHYS_W-1:0] part_lim,
    input logic [ADDR_W-1:0] log_addr,
    input logic [N_CHIP-1:0] ce_n,
    input logic [N_PERI-1:0] pe_n,
    input logic              wr_n
);
    logic rst_q = 1'b0;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: pins parked high after a reset edge
    always @(negedge clk) begin
        if (rst_q) begin
            a_r1_reset_park: assert (&ce_n && &pe_n && wr_n);
        end
    end

    a_r9_single_enable: assert property (@(posedge clk) disable iff (rst)
        ($past(mem_big) ? ($countones(~{ce_n[3], ce_n[0], pe_n}) <= 1)
                        : ($countones(~{ce_n, pe_n}) <= 1)));

    a_r7_write_guard: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> $past(cyc_act && !cyc_prog && cyc_wr &&
                        (periph_sel || ({1'b0, log_addr} >= part_lim))));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !$past(cyc_act) |-> (&ce_n && &pe_n && wr_n));

    a_r3_pin4_parked: assert property (@(posedge clk) disable iff (rst)
        $past(mem_big) |-> ce_n[3]);

    a_r6_unmapped_fetch: assert property (@(posedge clk) disable iff (rst)
        $past(cyc_act && cyc_prog && ({1'b0, log_addr} >= part_lim))
            |-> (&ce_n && &pe_n && wr_n));
endmodule

bind bwce_decoder bwce_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cyc_act    (cyc_act),
    .cyc_prog   (cyc_prog),
    .cyc_wr     (cyc_wr),
    .periph_sel (periph_sel),
    .mem_big    (mem_big),
    .part_lim   (part_lim),
    .log_addr   (log_addr),
    .ce_n       (ce_n),
    .pe_n       (pe_n),
    .wr_n       (wr_n)
);

// File: tb/bwce_decoder_tb.sv
module bwce_decoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_act = 1'b0;
    logic        cyc_prog = 1'b0;
    logic        cyc_wr = 1'b0;
    logic        periph_sel = 1'b0;
    logic        mem_big = 1'b0;
    logic [16:0] part_lim = 17'h0;
    logic [15:0] log_addr = 16'h0;
    logic [3:0]  ce_n;
    logic [3:0]  pe_n;
    logic        wr_n;

    int n_vec = 0;
    int n_bad = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    bwce_decoder u_dut (
        .clk(clk), .rst(rst), .cyc_act(cyc_act), .cyc_prog(cyc_prog),
        .cyc_wr(cyc_wr), .periph_sel(periph_sel), .mem_big(mem_big),
        .part_lim(part_lim), .log_addr(log_addr),
        .ce_n(ce_n), .pe_n(pe_n), .wr_n(wr_n)
    );

    // expected pins {ce_n, pe_n, wr_n} from the requirements
    function automatic logic [8:0] model(input logic r, input logic act,
        input logic prog, input logic wr, input logic psel, input logic big,
        input logic [16:0] lim, input logic [15:0] a);
        logic [3:0] ce = 4'hF;
        logic [3:0] pe = 4'hF;
        logic       w  = 1'b1;
        logic       sram = 1'b0;
        logic       low = ({1'b0, a} < lim);
        if (!r && act) begin
            if (prog) begin
                sram = low;                       // R6, R5
            end else if (psel) begin
                pe[a[15:14]] = 1'b0;              // R4
                w = !wr;                          // R7
            end else begin
                sram = 1'b1;
                w = !(wr && !low);                // R7
            end
            if (sram) begin
                if (big) begin                    // R3
                    ce[0] = 1'b0;
                    ce[1] = !prog;
                    ce[2] = a[15];
                    ce[3] = 1'b1;
                end else begin                    // R2
                    ce[{!prog, a[15]}] = 1'b0;
                end
            end
        end
        return {ce, pe, w};
    endfunction

    function automatic string pick_tag(input logic r, input logic act,
        input logic prog, input logic wr, input logic psel, input logic big,
        input logic [16:0] lim, input logic [15:0] a);
        if (r) return "R1";
        if (!act) return "R8";
        if (prog && ({1'b0, a} >= lim)) return "R6";
        if (prog && psel) return "R5";
        if (wr) return "R7";
        if (!prog && psel) return "R4";
        if (big) return "R3";
        return "R2";
    endfunction

    task automatic drive(input logic r, input logic act, input logic prog,
        input logic wr, input logic psel, input logic big,
        input logic [16:0] lim, input logic [15:0] a);
        @(negedge clk);
        #1;
        rst = r; cyc_act = act; cyc_prog = prog; cyc_wr = wr;
        periph_sel = psel; mem_big = big; part_lim = lim; log_addr = a;
        exp_q.push_back(model(r, act, prog, wr, psel, big, lim, a));
        tag_q.push_back(pick_tag(r, act, prog, wr, psel, big, lim, a));
    endtask

    // monitor: results of the cycle driven one negedge earlier (R10)
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [8:0] e;
            logic [8:0] got;
            string      t;
            int         lows;
            e   = exp_q.pop_front();
            t   = tag_q.pop_front();
            got = {ce_n, pe_n, wr_n};
            n_vec++;
            if (got !== e) begin
                n_bad++;
                $display("FAIL %s (R10 latency) a=%h lim=%h: got %b expected %b",
                         t, log_addr, part_lim, got, e);
            end
            lows = mem_big ? $countones(~{ce_n[3], ce_n[0], pe_n})
                           : $countones(~{ce_n, pe_n});
            if (!rst && (lows > 1)) begin
                n_bad++;
                $display("FAIL R9 multiple enables low: got %0d expected <=1", lows);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] addrs[13];
        logic [16:0] lims[3];
        addrs = '{16'h0000, 16'h0001, 16'h3FFF, 16'h4000, 16'h7FFF, 16'h8000,
                  16'hBFFF, 16'hC000, 16'hFFFF, 16'h9FFF, 16'hA000, 16'h1234,
                  16'hD5A3};
        lims  = '{17'h0A000, 17'h00000, 17'h10000};
        // R1: reset with a busy-looking cycle presented
        drive(1, 1, 0, 1, 0, 0, 17'h10000, 16'h8000);
        drive(1, 1, 1, 0, 1, 1, 17'h10000, 16'h0000);
        // R8: idle
        drive(0, 0, 0, 1, 0, 0, 17'h10000, 16'h4000);
        for (int li = 0; li < 3; li++)
            for (int ai = 0; ai < 13; ai++)
                for (int m = 0; m < 16; m++)
                    drive(0, 1, m[0], m[1], m[2], m[3], lims[li], addrs[ai]);
        // R8 in both size settings
        drive(0, 0, 1, 0, 0, 1, 17'h10000, 16'h0000);
        drive(0, 0, 0, 0, 1, 0, 17'h10000, 16'hC000);
        // R1: reset mid-run, then resume
        drive(0, 1, 0, 1, 1, 0, 17'h0, 16'h4000);
        drive(1, 1, 0, 1, 1, 0, 17'h0, 16'h4000);
        drive(0, 1, 0, 1, 0, 0, 17'h0, 16'hF000);
        drive(0, 0, 0, 0, 0, 0, 17'h0, 16'h0);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule